// File: doc/BRIEF.md
# Host Bridge Transaction Routing Decoder

This block sits in a host bridge and picks a destination for every memory or I/O request that the processor issues. There are two possible destinations. One is the secondary graphics port. The other is the default downstream hub link, which takes everything that is not claimed. The choice depends on the request address and type, and on a set of configuration values:

- an I/O window, given as base and limit;
- two memory windows, one plain and one prefetchable, each given as base and limit;
- three legacy control bits: a colour-display enable, a monochrome-display enable and an ISA-alias enable.

The legacy display ranges outrank the programmable windows in a fixed order. The ISA-alias rule takes the upper three quarters of every 1 KB block inside the I/O window away from the graphics port. The legacy I/O ranges decode only address bits [9:0], so every alias above them matches too.

The block takes one request per clock. The decision is registered, so it appears together with a valid flag on the clock edge after the request is sampled. The block also keeps a registered flag that reports an illegal control-bit combination. This flag is refreshed on every clock, whether or not a request is present.

Top module: `rt_host_route`

## Requirements
- R1: While reset is high, and in the cycle after it, `route_valid`, `route_gfx` and `cfg_illegal` are 0. Since all control inputs are 0 out of reset, every request then goes to the hub link.
- R2: `route_valid` equals `req_valid` delayed by one clock. `route_gfx` = 1 means the graphics port and 0 means the hub link. `route_gfx` is 0 whenever `route_valid` is 0.
- R3: With `cfg_vga_en`=1 and `cfg_mda_en`=0, a memory request with address 000A0000h to 000BFFFFh goes to the graphics port, whatever the windows hold. Addresses just outside that span do not get this treatment.
- R4: With `cfg_vga_en`=1, an I/O request goes to the graphics port if address bits [9:0] lie in 3B0h–3BBh or in 3C0h–3DFh. Bits [15:10] may take any value. `cfg_isa_en` has no effect on this rule.
- R5: With `cfg_vga_en`=1, an I/O request with address bits [9:0] in 3BCh–3BFh goes to the hub link, even when the I/O window covers it.
- R6: With `cfg_vga_en`=1 and `cfg_mda_en`=1, the monochrome ranges go to the hub link: I/O [9:0] 3B0h–3BBh and memory 000B0000h–000B7FFFh. The other colour-display ranges still go to the graphics port.
- R7: With `cfg_vga_en`=0, the legacy ranges get no special routing. They go to the graphics port only if a window claims them.
- R8: An I/O request is claimed by the I/O window when `cfg_io_base` ≤ address[15:0] ≤ `cfg_io_limit`. A base above the limit claims nothing. The memory windows never claim an I/O request.
- R9: A memory request is claimed when address[31:20] lies, inclusive, between the base and limit of the plain memory window or of the prefetchable window. A base above its limit claims nothing. The I/O window never claims a memory request.
- R10: With `cfg_isa_en`=1, an I/O request inside the I/O window goes to the hub link when address bits [9:8] ≠ 00. When bits [9:8] = 00, the request still goes to the graphics port.
- R11: `cfg_illegal` is 1 exactly one clock after the inputs show `cfg_vga_en`=0 with `cfg_mda_en`=1. Routing in that state is the same as with `cfg_mda_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 32 | Request address |
| cfg_io_base | input | 16 | I/O window lower bound (inclusive) |
| cfg_io_limit | input | 16 | I/O window upper bound (inclusive) |
| cfg_mem_base | input | 12 | Memory window lower bound, address[31:20] |
| cfg_mem_limit | input | 12 | Memory window upper bound, address[31:20] |
| cfg_pref_base | input | 12 | Prefetchable window lower bound, address[31:20] |
| cfg_pref_limit | input | 12 | Prefetchable window upper bound, address[31:20] |
| cfg_vga_en | input | 1 | Colour-display legacy range enable |
| cfg_mda_en | input | 1 | Monochrome-display split enable |
| cfg_isa_en | input | 1 | ISA-alias exclusion enable |
| route_valid | output | 1 | Registered decision valid |
| route_gfx | output | 1 | Registered destination: 1 = graphics port, 0 = hub link |
| cfg_illegal | output | 1 | Registered illegal-combination flag |

## Verification
The hardest cases to reach are those where two rules claim the same request and only the precedence order decides the result. Examples are a monochrome port alias that also lies inside an open I/O window, and a colour-display port that the ISA-alias rule would otherwise strip. The vector table reaches each of these by opening the window or setting the ISA bit so that it overlaps the legacy range, then flipping the legacy bits across one vector. The illegal combination is driven both with and without a request in flight, so the flag can be seen apart from routing.

// File: rtl/rt_pkg.sv
`timescale 1ns/1ps
package rt_pkg;

    localparam int LEG_IO_W  = 10;
    localparam int LEG_MEM_W = 20;

    localparam logic [LEG_IO_W-1:0] IO_MONO_LO  = 10'h3B0;
    localparam logic [LEG_IO_W-1:0] IO_MONO_HI  = 10'h3BB;
    localparam logic [LEG_IO_W-1:0] IO_PORT_LO  = 10'h3BC;
    localparam logic [LEG_IO_W-1:0] IO_PORT_HI  = 10'h3BF;
    localparam logic [LEG_IO_W-1:0] IO_COLOR_LO = 10'h3C0;
    localparam logic [LEG_IO_W-1:0] IO_COLOR_HI = 10'h3DF;

    localparam logic [LEG_MEM_W-1:0] FB_ANY_LO  = 20'hA0000;
    localparam logic [LEG_MEM_W-1:0] FB_ANY_HI  = 20'hBFFFF;
    localparam logic [LEG_MEM_W-1:0] FB_MONO_LO = 20'hB0000;
    localparam logic [LEG_MEM_W-1:0] FB_MONO_HI = 20'hB7FFF;

    typedef enum logic {
        DEST_HUB = 1'b0,
        DEST_GFX = 1'b1
    } dest_e;

    typedef struct packed {
        logic fb_any;
        logic fb_mono;
        logic io_mono;
        logic io_port;
        logic io_color;
    } legacy_hit_t;

    typedef struct packed {
        logic vga;
        logic mono;
        logic isa;
    } route_ctl_t;

    typedef struct packed {
        logic  valid;
        dest_e dest;
        logic  illegal;
    } route_out_t;

    function automatic logic in_span_io(input logic [LEG_IO_W-1:0] v,
                                        input logic [LEG_IO_W-1:0] lo,
                                        input logic [LEG_IO_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic logic in_span_mem(input logic [LEG_MEM_W-1:0] v,
                                         input logic [LEG_MEM_W-1:0] lo,
                                         input logic [LEG_MEM_W-1:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // Offsets 100h..3FFh of each 1 KB block belong to the ISA alias space
    function automatic logic isa_alias_cut(input logic [LEG_IO_W-1:0] v);
        return v[9:8] != 2'b00;
    endfunction

    // Monochrome split only counts when the colour ranges are enabled
    function automatic route_ctl_t sanitize_ctl(input logic vga,
                                                input logic mda,
                                                input logic isa);
        route_ctl_t c;
        c.vga  = vga;
        c.mono = vga & mda;
        c.isa  = isa;
        return c;
    endfunction

    function automatic logic ctl_is_illegal(input logic vga, input logic mda);
        return !vga && mda;
    endfunction

endpackage

// File: rtl/rt_window_cmp.sv
`timescale 1ns/1ps
module rt_window_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] limit,
    output logic         hit
);
    // Inclusive compare; an inverted pair can never satisfy both terms
    always_comb begin
        hit = (addr >= base) && (addr <= limit);
    end
endmodule

// File: rtl/rt_legacy_decode.sv
`timescale 1ns/1ps
module rt_legacy_decode
    import rt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output legacy_hit_t       hit
);
    localparam int UPPER_W = ADDR_W - LEG_MEM_W;

    logic                 upper_clear;
    logic [LEG_MEM_W-1:0] mem_low;
    logic [LEG_IO_W-1:0]  io_low;

    generate
        if (UPPER_W > 0) begin : g_upper
            assign upper_clear = ~|addr[ADDR_W-1:LEG_MEM_W];
        end else begin : g_no_upper
            assign upper_clear = 1'b1;
        end
    endgenerate

    assign mem_low = addr[LEG_MEM_W-1:0];
    assign io_low  = addr[LEG_IO_W-1:0];

    always_comb begin
        hit.fb_any   = upper_clear && in_span_mem(mem_low, FB_ANY_LO,  FB_ANY_HI);
        hit.fb_mono  = upper_clear && in_span_mem(mem_low, FB_MONO_LO, FB_MONO_HI);
        hit.io_mono  = in_span_io(io_low, IO_MONO_LO,  IO_MONO_HI);
        hit.io_port  = in_span_io(io_low, IO_PORT_LO,  IO_PORT_HI);
        hit.io_color = in_span_io(io_low, IO_COLOR_LO, IO_COLOR_HI);
    end
endmodule

// File: rtl/rt_route_select.sv
`timescale 1ns/1ps
module rt_route_select
    import rt_pkg::*;
(
    input  logic        is_io,
    input  legacy_hit_t leg,
    input  logic        io_win_hit,
    input  logic        mem_win_hit,
    input  logic        isa_cut,
    input  route_ctl_t  ctl,
    output dest_e       dest
);
    always_comb begin
        dest = DEST_HUB;
        if (is_io) begin
            if (ctl.vga && leg.io_port) begin
                dest = DEST_HUB;
            end else if (ctl.mono && leg.io_mono) begin
                dest = DEST_HUB;
            end else if (ctl.vga && (leg.io_mono || leg.io_color)) begin
                dest = DEST_GFX;
            end else if (io_win_hit && !(ctl.isa && isa_cut)) begin
                dest = DEST_GFX;
            end
        end else begin
            if (ctl.mono && leg.fb_mono) begin
                dest = DEST_HUB;
            end else if (ctl.vga && leg.fb_any) begin
                dest = DEST_GFX;
            end else if (mem_win_hit) begin
                dest = DEST_GFX;
            end
        end
    end
endmodule

// File: rtl/rt_host_route.sv
`timescale 1ns/1ps
module rt_host_route
    import rt_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IO_W    = 16,
    parameter int MEM_LSB = 20
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic                      req_is_io,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic [IO_W-1:0]           cfg_io_base,
    input  logic [IO_W-1:0]           cfg_io_limit,
    input  logic [ADDR_W-MEM_LSB-1:0] cfg_mem_base,
    input  logic [ADDR_W-MEM_LSB-1:0] cfg_mem_limit,
    input  logic [ADDR_W-MEM_LSB-1:0] cfg_pref_base,
    input  logic [ADDR_W-MEM_LSB-1:0] cfg_pref_limit,
    input  logic                      cfg_vga_en,
    input  logic                      cfg_mda_en,
    input  logic                      cfg_isa_en,
    output logic                      route_valid,
    output logic                      route_gfx,
    output logic                      cfg_illegal
);
    localparam int MEM_W       = ADDR_W - MEM_LSB;
    localparam int NUM_MEM_WIN = 2;

    legacy_hit_t                   leg;
    route_ctl_t                    ctl;
    dest_e                         next_dest;
    logic                          io_win_hit;
    logic                          mem_win_any;
    logic [NUM_MEM_WIN-1:0]        mem_win_hit;
    logic [NUM_MEM_WIN-1:0][MEM_W-1:0] win_base;
    logic [NUM_MEM_WIN-1:0][MEM_W-1:0] win_limit;
    route_out_t                    out_q;

    assign ctl = sanitize_ctl(cfg_vga_en, cfg_mda_en, cfg_isa_en);

    rt_legacy_decode #(.ADDR_W(ADDR_W)) u_legacy (
        .addr (req_addr),
        .hit  (leg)
    );

    rt_window_cmp #(.W(IO_W)) u_io_win (
        .addr  (req_addr[IO_W-1:0]),
        .base  (cfg_io_base),
        .limit (cfg_io_limit),
        .hit   (io_win_hit)
    );

    assign win_base[0]  = cfg_mem_base;
    assign win_limit[0] = cfg_mem_limit;
    assign win_base[1]  = cfg_pref_base;
    assign win_limit[1] = cfg_pref_limit;

    generate
        for (genvar gi = 0; gi < NUM_MEM_WIN; gi++) begin : g_mem_win
            rt_window_cmp #(.W(MEM_W)) u_mem_win (
                .addr  (req_addr[ADDR_W-1:MEM_LSB]),
                .base  (win_base[gi]),
                .limit (win_limit[gi]),
                .hit   (mem_win_hit[gi])
            );
        end
    endgenerate

    assign mem_win_any = |mem_win_hit;

    rt_route_select u_select (
        .is_io       (req_is_io),
        .leg         (leg),
        .io_win_hit  (io_win_hit),
        .mem_win_hit (mem_win_any),
        .isa_cut     (isa_alias_cut(req_addr[LEG_IO_W-1:0])),
        .ctl         (ctl),
        .dest        (next_dest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.valid   <= 1'b0;
            out_q.dest    <= DEST_HUB;
            out_q.illegal <= 1'b0;
        end else begin
            out_q.valid   <= req_valid;
            out_q.dest    <= req_valid ? next_dest : DEST_HUB;
            out_q.illegal <= ctl_is_illegal(cfg_vga_en, cfg_mda_en);
        end
    end

    assign route_valid = out_q.valid;
    assign route_gfx   = (out_q.dest == DEST_GFX);
    assign cfg_illegal = out_q.illegal;

endmodule

// File: rtl/rt_host_route_chk.sv
`timescale 1ns/1ps
module rt_host_route_chk #(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_is_io,
    input logic [ADDR_W-1:0] req_addr,
    input logic [IO_W-1:0]   cfg_io_base,
    input logic [IO_W-1:0]   cfg_io_limit,
    input logic              cfg_vga_en,
    input logic              cfg_mda_en,
    input logic              cfg_isa_en,
    input logic              route_valid,
    input logic              route_gfx,
    input logic              cfg_illegal
);
    logic frame_hit;
    logic port_hit;
    logic mono_io_hit;
    logic io_outside;

    assign frame_hit   = (req_addr[ADDR_W-1:20] == '0) &&
                         (req_addr[19:0] >= 20'hA0000) && (req_addr[19:0] <= 20'hBFFFF);
    assign port_hit    = (req_addr[9:0] >= 10'h3BC) && (req_addr[9:0] <= 10'h3BF);
    assign mono_io_hit = (req_addr[9:0] >= 10'h3B0) && (req_addr[9:0] <= 10'h3BB);
    assign io_outside  = (req_addr[IO_W-1:0] < cfg_io_base) || (req_addr[IO_W-1:0] > cfg_io_limit);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!route_valid && !route_gfx && !cfg_illegal));

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> route_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!route_valid && !route_gfx));

    p_vga_frame_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_is_io && cfg_vga_en && !cfg_mda_en && frame_hit) |=> route_gfx);

    p_port_to_hub_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io && cfg_vga_en && port_hit) |=> !route_gfx);

    p_mono_to_hub_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io && cfg_vga_en && cfg_mda_en && mono_io_hit) |=> !route_gfx);

    p_io_outside_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io && !cfg_vga_en && io_outside) |=> !route_gfx);

    p_isa_cut_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_is_io && !cfg_vga_en && cfg_isa_en && (req_addr[9:8] != 2'b00))
        |=> !route_gfx);

    p_illegal_set_r11: assert property (@(posedge clk) disable iff (rst)
        (!cfg_vga_en && cfg_mda_en) |=> cfg_illegal);

    p_illegal_clear_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_vga_en || !cfg_mda_en) |=> !cfg_illegal);

endmodule

bind rt_host_route rt_host_route_chk #(.ADDR_W(ADDR_W), .IO_W(IO_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_io    (req_is_io),
    .req_addr     (req_addr),
    .cfg_io_base  (cfg_io_base),
    .cfg_io_limit (cfg_io_limit),
    .cfg_vga_en   (cfg_vga_en),
    .cfg_mda_en   (cfg_mda_en),
    .cfg_isa_en   (cfg_isa_en),
    .route_valid  (route_valid),
    .route_gfx    (route_gfx),
    .cfg_illegal  (cfg_illegal)
);

// File: tb/tb_rt_host_route.sv
`timescale 1ns/1ps
module tb_rt_host_route;

    typedef struct packed {
        logic [3:0]  rq;
        logic        io;
        logic [31:0] addr;
        logic [2:0]  ctl;   // {vga, mda, isa}
        logic [15:0] iob;
        logic [15:0] iol;
        logic [11:0] mb;
        logic [11:0] ml;
        logic [11:0] pb;
        logic [11:0] pl;
        logic        gfx;
        logic        ill;
    } vec_t;

    localparam int NV = 39;

    localparam vec_t VEC [NV] = '{
        // R3 colour frame buffer with VGA set
        '{4'd3, 1'b0, 32'h000A0000, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd3, 1'b0, 32'h000BFFFF, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd3, 1'b0, 32'h000C0000, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd3, 1'b0, 32'h0009FFFF, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd3, 1'b0, 32'h100A0000, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        // R4 legacy I/O ranges and aliases
        '{4'd4, 1'b1, 32'h000003B0, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd4, 1'b1, 32'h0000FFDF, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd4, 1'b1, 32'h00007BBB, 3'b101, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd4, 1'b1, 32'h000003E0, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        // R5 port block stays on hub, even inside an open I/O window
        '{4'd5, 1'b1, 32'h000003BF, 3'b100, 16'h0000, 16'hFFFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd5, 1'b1, 32'h000013BC, 3'b100, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        // R6 monochrome split
        '{4'd6, 1'b1, 32'h000003B4, 3'b110, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd6, 1'b0, 32'h000B0000, 3'b110, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd6, 1'b0, 32'h000B7FFF, 3'b110, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd6, 1'b0, 32'h000B8000, 3'b110, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd6, 1'b1, 32'h000003C5, 3'b110, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd6, 1'b1, 32'h000003BF, 3'b110, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        // R7 legacy ranges without VGA
        '{4'd7, 1'b1, 32'h000003C0, 3'b000, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd7, 1'b0, 32'h000A0000, 3'b000, 16'hFFFF, 16'h0000, 12'h000, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd7, 1'b0, 32'h000A0000, 3'b000, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd7, 1'b1, 32'h000003BC, 3'b000, 16'h0300, 16'h03FF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        // R10 ISA alias cut
        '{4'd10, 1'b1, 32'h000003BC, 3'b001, 16'h0300, 16'h03FF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd10, 1'b1, 32'h00001000, 3'b001, 16'h1000, 16'h1FFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd10, 1'b1, 32'h000010FF, 3'b001, 16'h1000, 16'h1FFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd10, 1'b1, 32'h00001100, 3'b001, 16'h1000, 16'h1FFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        // R8 I/O window edges and inverted window
        '{4'd8, 1'b1, 32'h00002000, 3'b000, 16'h1000, 16'h1FFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd8, 1'b1, 32'h00001FFF, 3'b000, 16'h1000, 16'h1FFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd8, 1'b1, 32'h00000FFF, 3'b000, 16'h1000, 16'h1FFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd8, 1'b1, 32'h00001800, 3'b000, 16'h1FFF, 16'h1000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd8, 1'b1, 32'h00000500, 3'b000, 16'hFFFF, 16'h0000, 12'h000, 12'hFFF, 12'h000, 12'hFFF, 1'b0, 1'b0},
        // R9 memory and prefetchable windows
        '{4'd9, 1'b0, 32'h10000000, 3'b000, 16'hFFFF, 16'h0000, 12'h100, 12'h1FF, 12'hFFF, 12'h000, 1'b1, 1'b0},
        '{4'd9, 1'b0, 32'h20000000, 3'b000, 16'hFFFF, 16'h0000, 12'h100, 12'h1FF, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd9, 1'b0, 32'h300FFFFF, 3'b000, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'h300, 12'h300, 1'b1, 1'b0},
        '{4'd9, 1'b0, 32'h30100000, 3'b000, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'h300, 12'h300, 1'b0, 1'b0},
        '{4'd9, 1'b0, 32'h18000000, 3'b000, 16'hFFFF, 16'h0000, 12'h200, 12'h100, 12'hFFF, 12'h000, 1'b0, 1'b0},
        '{4'd9, 1'b0, 32'h00001500, 3'b000, 16'h1000, 16'h1FFF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b0},
        // R11 illegal combination, routed as if monochrome split were off
        '{4'd11, 1'b1, 32'h000003B0, 3'b010, 16'hFFFF, 16'h0000, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b0, 1'b1},
        '{4'd11, 1'b1, 32'h000003B0, 3'b010, 16'h0300, 16'h03FF, 12'hFFF, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b1},
        '{4'd11, 1'b0, 32'h000B0000, 3'b010, 16'hFFFF, 16'h0000, 12'h000, 12'h000, 12'hFFF, 12'h000, 1'b1, 1'b1}
    };

    logic        clk;
    logic        rst;
    logic        req_valid;
    logic        req_is_io;
    logic [31:0] req_addr;
    logic [15:0] cfg_io_base;
    logic [15:0] cfg_io_limit;
    logic [11:0] cfg_mem_base;
    logic [11:0] cfg_mem_limit;
    logic [11:0] cfg_pref_base;
    logic [11:0] cfg_pref_limit;
    logic        cfg_vga_en;
    logic        cfg_mda_en;
    logic        cfg_isa_en;
    logic        route_valid;
    logic        route_gfx;
    logic        cfg_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    logic finished = 1'b0;

    rt_host_route dut (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_is_io      (req_is_io),
        .req_addr       (req_addr),
        .cfg_io_base    (cfg_io_base),
        .cfg_io_limit   (cfg_io_limit),
        .cfg_mem_base   (cfg_mem_base),
        .cfg_mem_limit  (cfg_mem_limit),
        .cfg_pref_base  (cfg_pref_base),
        .cfg_pref_limit (cfg_pref_limit),
        .cfg_vga_en     (cfg_vga_en),
        .cfg_mda_en     (cfg_mda_en),
        .cfg_isa_en     (cfg_isa_en),
        .route_valid    (route_valid),
        .route_gfx      (route_gfx),
        .cfg_illegal    (cfg_illegal)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        req_is_io      = v.io;
        req_addr       = v.addr;
        cfg_vga_en     = v.ctl[2];
        cfg_mda_en     = v.ctl[1];
        cfg_isa_en     = v.ctl[0];
        cfg_io_base    = v.iob;
        cfg_io_limit   = v.iol;
        cfg_mem_base   = v.mb;
        cfg_mem_limit  = v.ml;
        cfg_pref_base  = v.pb;
        cfg_pref_limit = v.pl;
    endtask

    task automatic close_all();
        cfg_io_base = 16'hFFFF; cfg_io_limit = 16'h0000;
        cfg_mem_base = 12'hFFF; cfg_mem_limit = 12'h000;
        cfg_pref_base = 12'hFFF; cfg_pref_limit = 12'h000;
        cfg_vga_en = 1'b0; cfg_mda_en = 1'b0; cfg_isa_en = 1'b0;
    endtask

    initial begin
        #500000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_is_io = 1'b0;
        req_addr = 32'h0;
        close_all();
        // keep a legacy request present during reset to show it is ignored
        req_valid = 1'b1;
        req_addr  = 32'h000A0000;
        cfg_vga_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "valid in reset", route_valid, 1'b0);
        check("R1", "gfx in reset", route_gfx, 1'b0);
        check("R1", "illegal in reset", cfg_illegal, 1'b0);
        req_valid = 1'b0;
        close_all();
        rst = 1'b0;
        // R1: with controls at 0 a legacy frame request goes to the hub
        req_valid = 1'b1; req_is_io = 1'b0; req_addr = 32'h000A0000;
        @(posedge clk); @(negedge clk);
        check("R1", "post-reset valid", route_valid, 1'b1);
        check("R1", "post-reset hub", route_gfx, 1'b0);

        // table walk: each request decided one edge later (R2)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            req_valid = 1'b1;
            @(posedge clk); @(negedge clk);
            check($sformatf("R%0d vec%0d", VEC[i].rq, i), "valid", route_valid, 1'b1);
            check($sformatf("R%0d vec%0d", VEC[i].rq, i), "gfx", route_gfx, VEC[i].gfx);
            check($sformatf("R%0d vec%0d", VEC[i].rq, i), "illegal", cfg_illegal, VEC[i].ill);
        end

        // R2: no request means no valid and no graphics select
        close_all();
        cfg_vga_en = 1'b1;
        req_valid = 1'b0; req_is_io = 1'b0; req_addr = 32'h000A0000;
        @(posedge clk); @(negedge clk);
        check("R2", "idle valid", route_valid, 1'b0);
        check("R2", "idle gfx", route_gfx, 1'b0);

        // R11: illegal flag tracks config without any request
        cfg_vga_en = 1'b0; cfg_mda_en = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R11", "flag without request", cfg_illegal, 1'b1);
        check("R11", "no valid without request", route_valid, 1'b0);
        cfg_mda_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11", "flag clears", cfg_illegal, 1'b0);

        // R1: reset in the middle of traffic clears all outputs
        cfg_vga_en = 1'b0; cfg_mda_en = 1'b1;
        req_valid = 1'b1; req_is_io = 1'b0; req_addr = 32'h000A0000;
        cfg_mem_base = 12'h000; cfg_mem_limit = 12'h000;
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", "mid reset valid", route_valid, 1'b0);
        check("R1", "mid reset gfx", route_gfx, 1'b0);
        check("R1", "mid reset illegal", cfg_illegal, 1'b0);
        rst = 1'b0;
        req_valid = 1'b0;
        close_all();
        @(posedge clk); @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule